// File: doc/BRIEF.md
# PWM Output Action Qualifier with Continuous Force

This block turns timebase events into two pulse-width-modulated outputs, A and B. A separate timebase supplies a tick enable, a counter-zero strobe, a period-match strobe, the counter direction and the counter value. The block compares the counter with two compare values to find compare-A and compare-B matches while counting up. Each output has its own 16-bit action word. The word gives every event a 2-bit code that leaves the output alone, drives it low, drives it high or toggles it.

Software can pin either output low or high through a 4-bit force word. That word is a shadow copy. It becomes active only on a selectable reload event: counter zero, period match, either of the two, or the next tick. While a force is active it overrides every event-driven action. When the force is released, the output holds its value until a later event changes it.

The usual up-count setup drives the output high at zero and at period, and drives it low at the compare match. The high time in ticks then equals the compare value.

Top module: `pwm_action_qualifier`

## Requirements
- R1: An action code of 2'b00 leaves the output unchanged, 2'b01 drives it low, 2'b10 drives it high and 2'b11 inverts it.
- R2: In each action word, bits [1:0] act on counter zero, bits [3:2] on period match, bits [5:4] on a compare-A match and bits [9:8] on a compare-B match. All other bits have no effect. Output A uses `act_a`, output B uses `act_b`, and the two outputs are independent.
- R3: A compare event occurs only on a tick where `count_up` is 1 and `counter` equals the compare value.
- R4: When events coincide on one tick, the highest-ranked event whose code is not 2'b00 is applied. The ranking from highest to lowest is period, compare-B, compare-A, zero.
- R5: In the force word, bits [1:0] serve output A and bits [3:2] serve output B. Code 01 holds the output low and code 10 holds it high. Codes 00 and 11 apply no force. An active force overrides all event actions.
- R6: `reload_sel` sets when the shadow force word becomes active: 2'b00 on a zero tick, 2'b01 on a period tick, 2'b10 on either, 2'b11 on any tick. Until that event, a change to the shadow word has no effect on the outputs.
- R7: When a force is released, the output keeps its forced level until a later event acts on it.
- R8: On a cycle with `tick` low, all events and reloads are ignored and the outputs do not change.
- R9: After synchronous reset, both outputs are low and no force is active.
- R10: With the action word set to high at zero, high at period and low at the compare match, the output is high for exactly the compare value's number of ticks, counted over the counter values 0 to period-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase advanced this cycle; qualifies every event |
| at_zero | input | 1 | Counter is at zero |
| at_period | input | 1 | Counter is at the period value |
| count_up | input | 1 | 1 when the counter is counting up |
| counter | input | 16 | Timebase counter value |
| cmp_a | input | 16 | Compare value A |
| cmp_b | input | 16 | Compare value B |
| act_a | input | 16 | Action word for output A |
| act_b | input | 16 | Action word for output B |
| force_shadow | input | 4 | Shadow force word: [1:0] for A, [3:2] for B |
| reload_sel | input | 2 | Selects the force reload event |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
The bench targets coincident events: zero with period, compare-A equal to compare-B, and compare-A at counter zero. A design with the ranking reversed would drive the opposite level. A design that let a 2'b00 code win would leave the output stuck. The bench also looks at force reload timing for each selector value. A design that copied the shadow word at once, or on the wrong strobe, would change the output one or more ticks early. Finally, the bench covers force release, down-counting compare matches and cycles without a tick. A design that fell back to its stale pre-force level would show the wrong value after release. A design that matched while counting down, or acted on untick'd strobes, would toggle the output where it must stay still.

// File: rtl/pwm_aq_pkg.sv
package pwm_aq_pkg;

    localparam int CNT_W   = 16;
    localparam int WORD_W  = 16;
    localparam int NUM_OUT = 2;
    localparam int FRC_W   = 2 * NUM_OUT;

    // Bit positions of the event fields inside an action word
    localparam int ZRO_LSB = 0;
    localparam int PRD_LSB = 2;
    localparam int CPA_LSB = 4;
    localparam int CPB_LSB = 8;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PERIOD = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } reload_e;

    typedef struct packed {
        logic prd;
        logic cmpb;
        logic cmpa;
        logic zro;
    } evt_t;

    typedef struct packed {
        logic on;
        logic level;
    } force_t;

    function automatic act_e field_of(input logic [WORD_W-1:0] word, input int lsb);
        return act_e'(word[lsb +: 2]);
    endfunction

    // Highest-ranked event carrying a non-empty code wins
    function automatic act_e pick_action(input evt_t e, input logic [WORD_W-1:0] word);
        act_e r;
        r = ACT_NONE;
        if (e.zro  && field_of(word, ZRO_LSB) != ACT_NONE) r = field_of(word, ZRO_LSB);
        if (e.cmpa && field_of(word, CPA_LSB) != ACT_NONE) r = field_of(word, CPA_LSB);
        if (e.cmpb && field_of(word, CPB_LSB) != ACT_NONE) r = field_of(word, CPB_LSB);
        if (e.prd  && field_of(word, PRD_LSB) != ACT_NONE) r = field_of(word, PRD_LSB);
        return r;
    endfunction

    function automatic logic apply_action(input act_e a, input logic cur);
        case (a)
            ACT_LOW:    return 1'b0;
            ACT_HIGH:   return 1'b1;
            ACT_TOGGLE: return ~cur;
            default:    return cur;
        endcase
    endfunction

    function automatic force_t decode_force(input logic [1:0] code);
        force_t f;
        f.on    = (code == 2'b01) || (code == 2'b10);
        f.level = (code == 2'b10);
        return f;
    endfunction

endpackage

// File: rtl/aq_event_detect.sv
module aq_event_detect
    import pwm_aq_pkg::*;
(
    input  logic             tick,
    input  logic             at_zero,
    input  logic             at_period,
    input  logic             count_up,
    input  logic [CNT_W-1:0] counter,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    output evt_t             evt
);
    always_comb begin
        evt.zro  = tick && at_zero;
        evt.prd  = tick && at_period;
        evt.cmpa = tick && count_up && (counter == cmp_a);
        evt.cmpb = tick && count_up && (counter == cmp_b);
    end
endmodule

// File: rtl/aq_force_reload.sv
module aq_force_reload
    import pwm_aq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             at_zero,
    input  logic             at_period,
    input  logic [1:0]       reload_sel,
    input  logic [FRC_W-1:0] shadow,
    output logic [FRC_W-1:0] active
);
    logic load;

    always_comb begin
        case (reload_e'(reload_sel))
            RLD_ZERO:   load = tick && at_zero;
            RLD_PERIOD: load = tick && at_period;
            RLD_EITHER: load = tick && (at_zero || at_period);
            default:    load = tick;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)       active <= '0;
        else if (load) active <= shadow;
    end
endmodule

// File: rtl/aq_output_channel.sv
module aq_output_channel
    import pwm_aq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  evt_t              evt,
    input  logic [WORD_W-1:0] act_word,
    input  logic [1:0]        force_code,
    output logic              pwm,
    output logic              forced
);
    force_t frc;
    act_e   act;
    logic   level_q;

    always_comb begin
        frc = decode_force(force_code);
        act = pick_action(evt, act_word);
    end

    // While forced, the held level follows the force so release is seamless
    always_ff @(posedge clk) begin
        if (rst)         level_q <= 1'b0;
        else if (frc.on) level_q <= frc.level;
        else if (tick)   level_q <= apply_action(act, level_q);
    end

    assign pwm    = frc.on ? frc.level : level_q;
    assign forced = frc.on;
endmodule

// File: rtl/pwm_action_qualifier.sv
module pwm_action_qualifier
    import pwm_aq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              at_zero,
    input  logic              at_period,
    input  logic              count_up,
    input  logic [CNT_W-1:0]  counter,
    input  logic [CNT_W-1:0]  cmp_a,
    input  logic [CNT_W-1:0]  cmp_b,
    input  logic [WORD_W-1:0] act_a,
    input  logic [WORD_W-1:0] act_b,
    input  logic [FRC_W-1:0]  force_shadow,
    input  logic [1:0]        reload_sel,
    output logic              pwm_a,
    output logic              pwm_b
);
    evt_t               evt;
    logic [FRC_W-1:0]   force_act;
    logic [WORD_W-1:0]  words [NUM_OUT];
    logic [NUM_OUT-1:0] outs;
    logic [NUM_OUT-1:0] forced;

    assign words[0] = act_a;
    assign words[1] = act_b;

    aq_event_detect u_evt (
        .tick      (tick),
        .at_zero   (at_zero),
        .at_period (at_period),
        .count_up  (count_up),
        .counter   (counter),
        .cmp_a     (cmp_a),
        .cmp_b     (cmp_b),
        .evt       (evt)
    );

    aq_force_reload u_rld (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .at_zero    (at_zero),
        .at_period  (at_period),
        .reload_sel (reload_sel),
        .shadow     (force_shadow),
        .active     (force_act)
    );

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_ch
        aq_output_channel u_ch (
            .clk        (clk),
            .rst        (rst),
            .tick       (tick),
            .evt        (evt),
            .act_word   (words[i]),
            .force_code (force_act[2*i +: 2]),
            .pwm        (outs[i]),
            .forced     (forced[i])
        );
    end

    assign pwm_a = outs[0];
    assign pwm_b = outs[1];
endmodule

// File: rtl/pwm_aq_checker.sv
module pwm_aq_checker (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        at_period,
    input logic [15:0] act_a,
    input logic [1:0]  reload_sel,
    input logic [3:0]  force_shadow,
    input logic        pwm_a,
    input logic        pwm_b,
    input logic [1:0]  forced
);
    a_r9_reset_low: assert property (@(posedge clk)
        rst |=> (!pwm_a && !pwm_b));

    a_r8_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(pwm_a) && $stable(pwm_b)));

    a_r5_immediate_force_low: assert property (@(posedge clk) disable iff (rst)
        (tick && reload_sel == 2'b11 && force_shadow[1:0] == 2'b01) |=> !pwm_a);

    a_r7_release_holds: assert property (@(posedge clk) disable iff (rst)
        $fell(forced[0]) |-> (pwm_a == $past(pwm_a)));

    a_r4_period_high_applies: assert property (@(posedge clk) disable iff (rst)
        (tick && at_period && act_a[3:2] == 2'b10) |=> (pwm_a || forced[0]));
endmodule

bind pwm_action_qualifier pwm_aq_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick         (tick),
    .at_period    (at_period),
    .act_a        (act_a),
    .reload_sel   (reload_sel),
    .force_shadow (force_shadow),
    .pwm_a        (pwm_a),
    .pwm_b        (pwm_b),
    .forced       (forced)
);

// File: tb/sim_pwm_action_qualifier.sv
module sim_pwm_action_qualifier;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0, at_zero = 1'b0, at_period = 1'b0, count_up = 1'b1;
    logic [15:0] counter = '0, cmp_a = 16'hFFFF, cmp_b = 16'hFFFF;
    logic [15:0] act_a = '0, act_b = '0;
    logic [3:0]  force_shadow = '0;
    logic [1:0]  reload_sel = 2'b11;
    logic        pwm_a, pwm_b;
    int          checks = 0;
    int          errors = 0;

    always #2 clk = ~clk;

    pwm_action_qualifier u0 (
        .clk(clk), .rst(rst), .tick(tick), .at_zero(at_zero), .at_period(at_period),
        .count_up(count_up), .counter(counter), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .act_a(act_a), .act_b(act_b), .force_shadow(force_shadow),
        .reload_sel(reload_sel), .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    task automatic check(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", req, got, exp);
        end
    endtask

    task automatic check_int(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Drive one cycle at a falling edge, sample at the next falling edge
    task automatic step(input logic tk, input logic z, input logic p,
                        input logic up, input logic [15:0] c);
        tick = tk; at_zero = z; at_period = p; count_up = up; counter = c;
        @(negedge clk);
        tick = 1'b0; at_zero = 1'b0; at_period = 1'b0;
    endtask

    task automatic t_reset;
        check("R9 reset pwm_a", pwm_a, 1'b0);
        check("R9 reset pwm_b", pwm_b, 1'b0);
        step(1, 0, 0, 1, 16'd9);
        check("R9 no force after reset", pwm_a, 1'b0);
    endtask

    task automatic t_encoding;
        act_a = 16'h0002; step(1, 1, 0, 1, 0); check("R1 code 10 high", pwm_a, 1'b1);
        act_a = 16'h0001; step(1, 1, 0, 1, 0); check("R1 code 01 low", pwm_a, 1'b0);
        act_a = 16'h0003; step(1, 1, 0, 1, 0); check("R1 toggle to high", pwm_a, 1'b1);
        step(1, 1, 0, 1, 0);                   check("R1 toggle to low", pwm_a, 1'b0);
        act_a = 16'h0002; step(1, 1, 0, 1, 0);
        act_a = 16'h0000; step(1, 1, 0, 1, 0); check("R1 code 00 keeps", pwm_a, 1'b1);
    endtask

    task automatic t_tick;
        act_a = 16'h0001;
        step(0, 1, 0, 1, 0); check("R8 no tick ignores zero", pwm_a, 1'b1);
        step(1, 1, 0, 1, 0); check("R8 tick applies zero", pwm_a, 1'b0);
    endtask

    task automatic t_fields;
        cmp_a = 16'd5; cmp_b = 16'd7;
        act_a = 16'h0080; step(1, 0, 0, 1, 16'd5); check("R2 bits 7:6 unused", pwm_a, 1'b0);
        act_a = 16'h0020; step(1, 0, 0, 1, 16'd5); check("R2 bits 5:4 compare A", pwm_a, 1'b1);
        act_a = 16'h0100; step(1, 0, 0, 1, 16'd7); check("R2 bits 9:8 compare B", pwm_a, 1'b0);
        act_a = 16'h0008; step(1, 0, 1, 1, 16'd9); check("R2 bits 3:2 period", pwm_a, 1'b1);
        act_a = 16'h0000; act_b = 16'h0200;
        step(1, 0, 0, 1, 16'd7);
        check("R2 B uses act_b", pwm_b, 1'b1);
        check("R2 A independent of act_b", pwm_a, 1'b1);
        act_b = 16'h0001; step(1, 1, 0, 1, 0); check("R2 B zero low", pwm_b, 1'b0);
        act_b = 16'h0000;
    endtask

    task automatic t_compare_dir;
        cmp_a = 16'd5; act_a = 16'h0010;
        step(1, 0, 0, 0, 16'd5); check("R3 no match counting down", pwm_a, 1'b1);
        step(1, 0, 0, 1, 16'd4); check("R3 no match on unequal", pwm_a, 1'b1);
        step(1, 0, 0, 1, 16'd5); check("R3 match up and equal", pwm_a, 1'b0);
    endtask

    task automatic t_priority;
        cmp_a = 16'hFFFF; cmp_b = 16'hFFFF;
        act_a = 16'h0002; step(1, 1, 0, 1, 0);
        act_a = 16'h0006; step(1, 1, 1, 1, 16'd9); check("R4 period beats zero", pwm_a, 1'b0);
        cmp_a = 16'd3; cmp_b = 16'd3;
        act_a = 16'h0210; step(1, 0, 0, 1, 16'd3); check("R4 compare B beats A", pwm_a, 1'b1);
        cmp_a = 16'd0; cmp_b = 16'hFFFF;
        act_a = 16'h0012; step(1, 1, 0, 1, 0); check("R4 compare A beats zero", pwm_a, 1'b0);
        cmp_a = 16'hFFFF;
        act_a = 16'h0002; step(1, 1, 1, 1, 0); check("R4 empty period code skipped", pwm_a, 1'b1);
        act_a = 16'h0000;
    endtask

    task automatic t_force;
        reload_sel = 2'b11;
        force_shadow = 4'b0001; step(1, 0, 0, 1, 16'd9); check("R5 force A low", pwm_a, 1'b0);
        act_a = 16'h0002; step(1, 1, 0, 1, 0); check("R5 force overrides event", pwm_a, 1'b0);
        force_shadow = 4'b0010; step(1, 0, 0, 1, 16'd9); check("R5 force A high", pwm_a, 1'b1);
        force_shadow = 4'b1010; step(1, 0, 0, 1, 16'd9); check("R5 force B high", pwm_b, 1'b1);
        act_a = 16'h0000;
        force_shadow = 4'b1011; step(1, 0, 0, 1, 16'd9); check("R7 code 11 releases, holds", pwm_a, 1'b1);
        act_a = 16'h0001; step(1, 1, 0, 1, 0); check("R7 events resume after release", pwm_a, 1'b0);
        check("R5 B still forced", pwm_b, 1'b1);
        act_a = 16'h0000;
        force_shadow = 4'b0000; step(1, 0, 0, 1, 16'd9); check("R7 B holds after release", pwm_b, 1'b1);
        act_b = 16'h0001; step(1, 1, 0, 1, 0); check("R7 B low by event", pwm_b, 1'b0);
        act_b = 16'h0000;
    endtask

    task automatic t_reload;
        reload_sel = 2'b00; force_shadow = 4'b0010;
        step(1, 0, 0, 1, 16'd9); check("R6 zero sel waits", pwm_a, 1'b0);
        step(1, 0, 1, 1, 16'd9); check("R6 zero sel ignores period", pwm_a, 1'b0);
        step(1, 1, 0, 1, 0);     check("R6 zero sel loads at zero", pwm_a, 1'b1);
        force_shadow = 4'b0000; step(1, 1, 0, 1, 0);
        reload_sel = 2'b01; force_shadow = 4'b0001;
        step(1, 1, 0, 1, 0);     check("R6 period sel ignores zero", pwm_a, 1'b1);
        step(1, 0, 1, 1, 16'd9); check("R6 period sel loads at period", pwm_a, 1'b0);
        force_shadow = 4'b0000; step(1, 0, 1, 1, 16'd9);
        reload_sel = 2'b10; force_shadow = 4'b0010;
        step(1, 0, 0, 1, 16'd9); check("R6 either sel waits", pwm_a, 1'b0);
        step(1, 0, 1, 1, 16'd9); check("R6 either sel loads at period", pwm_a, 1'b1);
        force_shadow = 4'b0001;
        step(1, 1, 0, 1, 0);     check("R6 either sel loads at zero", pwm_a, 1'b0);
        force_shadow = 4'b0000; step(1, 1, 0, 1, 0);
        reload_sel = 2'b11; force_shadow = 4'b0010;
        step(0, 0, 0, 1, 16'd9); check("R6 R8 now sel needs tick", pwm_a, 1'b0);
        step(1, 0, 0, 1, 16'd9); check("R6 now sel loads on tick", pwm_a, 1'b1);
        force_shadow = 4'b0000; step(1, 0, 0, 1, 16'd9);
    endtask

    task automatic t_duty;
        int high_a = 0;
        int high_b = 0;
        cmp_a = 16'd3; cmp_b = 16'd5;
        act_a = 16'h001A; act_b = 16'h010A;
        for (int cyc = 0; cyc < 2; cyc++) begin
            for (int c = 0; c <= 8; c++) begin
                step(1, c == 0, c == 8, 1, 16'(c));
                if (cyc == 1 && c < 8) begin
                    if (pwm_a) high_a++;
                    if (pwm_b) high_b++;
                end
            end
        end
        check_int("R10 duty A ticks", high_a, 3);
        check_int("R10 duty B ticks", high_b, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_encoding;
        t_tick;
        t_fields;
        t_compare_dir;
        t_priority;
        t_force;
        t_reload;
        t_duty;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule